// File: doc/BRIEF.md
# Word-only SRAM controller with read-modify-write

This block connects a single requestor to an external synchronous SRAM whose data bus only moves whole 32-bit words. The requestor can read or write a byte, a halfword or a word, and can ask for atomic bit operations by setting the top address bit, which opens an alias view of the same SRAM words. Every access the SRAM sees is a full-word cycle. Any write that touches only some byte lanes, and every alias bit operation, is carried out as a read, a merge and a write-back of the whole word.

The controller presents a new word address on every SRAM cycle, so the memory needs no address counter of its own. It only produces back-to-back reads when the requestor asks for a multi-word read through the length field; it never lengthens a transfer by itself. A new request is taken only after the previous sequence has completely finished, so nothing can come between the read and the write-back of a read-modify-write.

Requests use a valid/ready handshake. Read data (and the old word of a test-and-set) come back on a response strobe in the cycle the SRAM delivers them.

Top module: `sram_word_ctrl`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `sram_cs_n`, `sram_oe_n` and `sram_we_n` are all 1.
- R2: A read accepted at clock edge E drives one SRAM read cycle in the cycle after E (`sram_cs_n`=0, `sram_oe_n`=0, `sram_we_n`=1, `sram_addr` = `req_addr[ADDR_W+1:2]`). One cycle later `rsp_valid` is 1 and `rsp_rdata` holds the whole 32-bit word, whatever the byte enables.
- R3: A read with `req_len`=N makes exactly N+1 read cycles on consecutive clocks at word addresses base, base+1, ... base+N. It returns N+1 responses in that order, each one cycle after its read cycle. The bus goes idle right after the last beat.
- R4: A plain write with `req_be`=4'b1111 makes a single SRAM write cycle in the cycle after acceptance (`sram_we_n`=0, `sram_oe_n`=1, data = `req_wdata`), with no SRAM read cycle. `req_ready` returns the cycle after that.
- R5: A plain write with a byte-enable other than all-zeros or all-ones proceeds in three cycles. First comes a read cycle, then a cycle with the bus idle while the old word returns, then a write cycle. The written word takes byte lane i (bits 8i+7:8i) from `req_wdata` where `req_be[i]`=1 and from the old word elsewhere.
- R6: A plain write with `req_be`=4'b0000 is accepted and completes with no SRAM cycle; `req_ready` stays 1 and memory is unchanged.
- R7: `req_addr[31]`=1 selects the alias window, and `req_addr[30:29]` picks the operation: 00 plain write, 01 bit set, 10 bit clear, 11 test-and-set. Alias plain writes follow R4/R5/R6. Bit operations always use the R5 read-modify-write timing and ignore `req_be`.
- R8: Bit set writes back old | `req_wdata`; bit clear writes back old & ~`req_wdata`.
- R9: Test-and-set returns the old word with `rsp_valid`=1 in the cycle between its read and write cycles, then writes back old | `req_wdata`.
- R10: `req_ready` is 0 from acceptance until the sequence has ended. Requests presented while it is 0 are not taken and cause no SRAM cycle.
- R11: In every SRAM write cycle `sram_oe_n` is 1, and no cycle drives `sram_oe_n` and `sram_we_n` low together.
- R12: Writes ignore `req_len`: every write request, of any kind, writes exactly one word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write or bit operation, 0 = read |
| req_addr | input | 32 | Byte address; bit 31 alias window, bits 30:29 alias operation |
| req_be | input | LANES | Byte-lane enables for plain writes |
| req_wdata | input | 8*LANES | Write data or bit mask |
| req_len | input | $clog2(MAX_BURST) | Read beats minus one |
| rsp_valid | output | 1 | Read data or old test-and-set word present |
| rsp_rdata | output | 8*LANES | Full word returned |
| sram_cs_n | output | 1 | SRAM chip select, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_addr | output | ADDR_W | SRAM word address, driven for each cycle |
| sram_wdata | output | 8*LANES | Data to SRAM |
| sram_rdata | input | 8*LANES | Data from SRAM, one cycle after a read cycle |

## Verification
The assertions check on every cycle the rules that hold whatever the data is. Output enable is never asserted during a write. No bus cycle runs while the controller reports ready. Consecutive read cycles step the address by one. Every response follows a read cycle. Every write that comes after a busy cycle is preceded by a read two cycles earlier. A zero-lane plain write leaves the bus idle. Only the bench's scenarios can show the data results: the merged byte lanes, set, clear and test-and-set words, and the returned old word. They also show the exact number of beats for a given length, that a full-word write makes no read, and that a request held during a busy sequence is never taken.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    OP_PLAIN = 2'b00,
    OP_SET   = 2'b01,
    OP_CLR   = 2'b10,
    OP_TAS   = 2'b11
  } bitop_e;

  typedef enum logic [1:0] {
    PATH_READ,
    PATH_DIRECT,
    PATH_RMW,
    PATH_NONE
  } path_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TAIL,
    ST_MERGE,
    ST_WRITE
  } seq_state_e;

endpackage

// File: rtl/sram_req_decode.sv
module sram_req_decode
  import sram_ctrl_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic             is_write,
  input  logic [2:0]       addr_top,
  input  logic [LANES-1:0] lane_en,
  output path_e            path,
  output bitop_e           op
);

  always_comb begin
    op = addr_top[2] ? bitop_e'(addr_top[1:0]) : OP_PLAIN;
    if (!is_write)           path = PATH_READ;
    else if (op != OP_PLAIN) path = PATH_RMW;
    else if (&lane_en)       path = PATH_DIRECT;
    else if (lane_en == '0)  path = PATH_NONE;
    else                     path = PATH_RMW;
  end

endmodule

// File: rtl/sram_lane_merge.sv
module sram_lane_merge
  import sram_ctrl_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0] old_word,
  input  logic [8*LANES-1:0] new_word,
  input  logic [LANES-1:0]   lane_en,
  input  bitop_e             op,
  output logic [8*LANES-1:0] merged
);

  logic [8*LANES-1:0] lane_mix;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_mix[8*i +: 8] = lane_en[i] ? new_word[8*i +: 8] : old_word[8*i +: 8];
  end

  always_comb begin
    case (op)
      OP_SET:  merged = old_word | new_word;
      OP_CLR:  merged = old_word & ~new_word;
      OP_TAS:  merged = old_word | new_word;
      default: merged = lane_mix;
    endcase
  end

endmodule

// File: rtl/sram_word_ctrl.sv
module sram_word_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int LANES     = 4,
  parameter int MAX_BURST = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         req_valid,
  output logic                         req_ready,
  input  logic                         req_write,
  input  logic [31:0]                  req_addr,
  input  logic [LANES-1:0]             req_be,
  input  logic [8*LANES-1:0]           req_wdata,
  input  logic [$clog2(MAX_BURST)-1:0] req_len,
  output logic                         rsp_valid,
  output logic [8*LANES-1:0]           rsp_rdata,
  output logic                         sram_cs_n,
  output logic                         sram_oe_n,
  output logic                         sram_we_n,
  output logic [ADDR_W-1:0]            sram_addr,
  output logic [8*LANES-1:0]           sram_wdata,
  input  logic [8*LANES-1:0]           sram_rdata
);

  localparam int DATA_W = 8 * LANES;
  localparam int LEN_W  = $clog2(MAX_BURST);

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_n_s = rst_pipe_q[1];

  // request decode
  path_e  dec_path;
  bitop_e dec_op;

  sram_req_decode #(.LANES(LANES)) u_decode (
    .is_write (req_write),
    .addr_top (req_addr[31:29]),
    .lane_en  (req_be),
    .path     (dec_path),
    .op       (dec_op)
  );

  logic unused_addr_bits;
  assign unused_addr_bits = ^{req_addr[28:ADDR_W+2], req_addr[1:0]};

  // sequence state
  seq_state_e          state_q, state_d;
  logic [ADDR_W-1:0]   addr_q, addr_d;
  logic [DATA_W-1:0]   wdata_q, wdata_d;
  logic [LANES-1:0]    be_q, be_d;
  bitop_e              op_q, op_d;
  logic [LEN_W-1:0]    len_q, len_d;
  logic [LEN_W-1:0]    beat_q, beat_d;
  logic                is_rd_q, is_rd_d;
  logic                rsp_pend_q, rsp_pend_d;
  logic                ld_en;
  logic [DATA_W-1:0]   merged_word;

  sram_lane_merge #(.LANES(LANES)) u_merge (
    .old_word (sram_rdata),
    .new_word (wdata_q),
    .lane_en  (be_q),
    .op       (op_q),
    .merged   (merged_word)
  );

  assign req_ready = (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    wdata_d = wdata_q;
    be_d    = be_q;
    op_d    = op_q;
    len_d   = len_q;
    beat_d  = beat_q;
    is_rd_d = is_rd_q;
    ld_en   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          ld_en   = 1'b1;
          addr_d  = req_addr[ADDR_W+1:2];
          wdata_d = req_wdata;
          be_d    = req_be;
          op_d    = dec_op;
          len_d   = req_len;
          beat_d  = '0;
          is_rd_d = !req_write;
          case (dec_path)
            PATH_READ, PATH_RMW: state_d = ST_READ;
            PATH_DIRECT:         state_d = ST_WRITE;
            default:             state_d = ST_IDLE;
          endcase
        end
      end
      ST_READ: begin
        ld_en = 1'b1;
        if (is_rd_q && beat_q != len_q) begin
          beat_d = beat_q + 1'b1;
          addr_d = addr_q + 1'b1;
        end else begin
          state_d = is_rd_q ? ST_TAIL : ST_MERGE;
        end
      end
      ST_MERGE: begin
        ld_en   = 1'b1;
        wdata_d = merged_word;
        state_d = ST_WRITE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign rsp_pend_d = (state_q == ST_READ) && is_rd_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q    <= ST_IDLE;
      rsp_pend_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      rsp_pend_q <= rsp_pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      op_q    <= OP_PLAIN;
      len_q   <= '0;
      beat_q  <= '0;
      is_rd_q <= 1'b0;
    end else if (ld_en) begin
      addr_q  <= addr_d;
      wdata_q <= wdata_d;
      be_q    <= be_d;
      op_q    <= op_d;
      len_q   <= len_d;
      beat_q  <= beat_d;
      is_rd_q <= is_rd_d;
    end
  end

  // SRAM pins and response
  assign sram_cs_n  = !((state_q == ST_READ) || (state_q == ST_WRITE));
  assign sram_oe_n  = (state_q != ST_READ);
  assign sram_we_n  = (state_q != ST_WRITE);
  assign sram_addr  = addr_q;
  assign sram_wdata = wdata_q;
  assign rsp_valid  = rsp_pend_q || ((state_q == ST_MERGE) && (op_q == OP_TAS));
  assign rsp_rdata  = sram_rdata;

  // assertions
  assert_oe_off_in_write_R11: assert property (@(posedge clk) disable iff (!rst_n_s)
    !sram_we_n |-> (sram_oe_n && !sram_cs_n));

  assert_no_cycle_when_ready_R10: assert property (@(posedge clk) disable iff (!rst_n_s)
    req_ready |-> sram_cs_n);

  assert_burst_addr_step_R3: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sram_oe_n && $past(!sram_oe_n)) |-> (sram_addr == ADDR_W'($past(sram_addr) + 1'b1)));

  assert_rsp_follows_read_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> $past(!sram_cs_n && !sram_oe_n));

  assert_writeback_after_read_R5: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!sram_we_n && $past(!req_ready)) |-> ($past(!sram_oe_n, 2) && $past(sram_cs_n)));

  assert_zero_lane_no_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_ready && req_write && (req_be == '0) && !req_addr[31])
      |=> (sram_cs_n && req_ready));

endmodule

// File: tb/sram_word_ctrl_bench.sv
`timescale 1ns/1ps
module sram_word_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic        req_write;
  logic [31:0] req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic [2:0]  req_len;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        sram_cs_n, sram_oe_n, sram_we_n;
  logic [15:0] sram_addr;
  logic [31:0] sram_wdata;
  logic [31:0] sram_rdata;

  int total = 0;
  int bad   = 0;
  int rd_cnt = 0;
  int wr_cnt = 0;

  logic [31:0] mem [0:255];
  logic        poke_en = 1'b0;
  logic [7:0]  poke_a;
  logic [31:0] poke_d;

  always #2.5 clk = ~clk;

  sram_word_ctrl u_sram_word_ctrl (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_be,
    .req_wdata, .req_len, .rsp_valid, .rsp_rdata, .sram_cs_n, .sram_oe_n,
    .sram_we_n, .sram_addr, .sram_wdata, .sram_rdata
  );

  // SRAM model: one-cycle read latency
  always @(posedge clk) begin
    if (poke_en) mem[poke_a] <= poke_d;
    if (!sram_cs_n && !sram_we_n) begin
      mem[sram_addr[7:0]] <= sram_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (!sram_cs_n && !sram_oe_n) begin
      sram_rdata <= mem[sram_addr[7:0]];
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [31:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = 8'(a); poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  function automatic logic [31:0] alias_addr(input logic [1:0] op, input int word);
    return {1'b1, op, 29'(word << 2)};
  endfunction

  // drive for one edge; returns at the negedge of the first cycle after acceptance
  task automatic issue(input logic w, input logic [31:0] a, input logic [3:0] be,
                       input logic [31:0] d, input logic [2:0] len);
    @(negedge clk);
    req_write = w; req_addr = a; req_be = be; req_wdata = d; req_len = len;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 32'd0);
    chk({sram_cs_n, sram_oe_n, sram_we_n} == 3'b111, "R1 strobes",
        32'({sram_cs_n, sram_oe_n, sram_we_n}), 32'h7);
  endtask

  task automatic t_read_single();
    poke(5, 32'h1122_3344);
    issue(1'b0, 32'd20, 4'b0001, 32'h0, 3'd0);
    chk({sram_cs_n, sram_oe_n, sram_we_n} == 3'b001, "R2 read strobes",
        32'({sram_cs_n, sram_oe_n, sram_we_n}), 32'h1);
    chk(sram_addr == 16'd5, "R2 read addr", 32'(sram_addr), 32'd5);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 32'h1122_3344, "R2 full word returned", rsp_rdata, 32'h1122_3344);
    chk(req_ready == 1'b0, "R10 busy during read", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk(req_ready == 1'b1 && !rsp_valid, "R2 done", 32'(req_ready), 32'd1);
  endtask

  task automatic t_read_burst();
    int r0;
    for (int k = 0; k < 4; k++) poke(16 + k, 32'hB000_0000 + 32'(k));
    r0 = rd_cnt;
    issue(1'b0, 32'd64, 4'b1111, 32'h0, 3'd3);
    for (int k = 0; k < 4; k++) begin
      chk(!sram_oe_n && sram_addr == 16'(16 + k), "R3 beat address", 32'(sram_addr), 32'(16 + k));
      if (k > 0)
        chk(rsp_valid && rsp_rdata == 32'hB000_0000 + 32'(k - 1), "R3 beat data",
            rsp_rdata, 32'hB000_0000 + 32'(k - 1));
      @(negedge clk);
    end
    chk(rsp_valid && rsp_rdata == 32'hB000_0003, "R3 last beat data", rsp_rdata, 32'hB000_0003);
    chk(sram_cs_n == 1'b1, "R3 no extra beat", 32'(sram_cs_n), 32'd1);
    settle();
    chk(rd_cnt - r0 == 4, "R3 read cycle count", 32'(rd_cnt - r0), 32'd4);
  endtask

  task automatic t_full_write();
    int r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    issue(1'b1, 32'd32, 4'b1111, 32'hDEAD_BEEF, 3'd7);
    chk({sram_cs_n, sram_oe_n, sram_we_n} == 3'b010, "R4 write strobes",
        32'({sram_cs_n, sram_oe_n, sram_we_n}), 32'h2);
    chk(sram_wdata == 32'hDEAD_BEEF && sram_addr == 16'd8, "R4 write data", sram_wdata, 32'hDEAD_BEEF);
    @(negedge clk);
    chk(req_ready && sram_cs_n, "R4 single cycle", 32'(req_ready), 32'd1);
    settle();
    chk(mem[8] == 32'hDEAD_BEEF, "R4 memory", mem[8], 32'hDEAD_BEEF);
    chk(rd_cnt == r0, "R4 no read cycle", 32'(rd_cnt - r0), 32'd0);
    chk(wr_cnt - w0 == 1, "R12 length ignored", 32'(wr_cnt - w0), 32'd1);
  endtask

  task automatic t_partial_write();
    poke(9, 32'hAABB_CCDD);
    issue(1'b1, 32'd36, 4'b0101, 32'h1122_3344, 3'd0);
    chk(!sram_oe_n && sram_we_n && sram_addr == 16'd9, "R5 read phase", 32'(sram_oe_n), 32'd0);
    @(negedge clk);
    chk(sram_cs_n == 1'b1 && !rsp_valid, "R5 return phase idle", 32'(sram_cs_n), 32'd1);
    @(negedge clk);
    chk(!sram_we_n && sram_wdata == 32'hAA22_CC44, "R5 merged byte lanes", sram_wdata, 32'hAA22_CC44);
    settle();
    chk(mem[9] == 32'hAA22_CC44, "R5 memory after byte merge", mem[9], 32'hAA22_CC44);
    issue(1'b1, 32'd36, 4'b1100, 32'h5566_7788, 3'd0);
    settle();
    chk(mem[9] == 32'h5566_CC44, "R5 halfword merge", mem[9], 32'h5566_CC44);
  endtask

  task automatic t_be_zero();
    int r0, w0;
    poke(10, 32'h1234_5678);
    r0 = rd_cnt; w0 = wr_cnt;
    issue(1'b1, 32'd40, 4'b0000, 32'hFFFF_FFFF, 3'd0);
    chk(req_ready && sram_cs_n, "R6 no cycle, still ready", 32'(sram_cs_n), 32'd1);
    settle();
    chk(rd_cnt == r0 && wr_cnt == w0, "R6 no SRAM activity", 32'(rd_cnt + wr_cnt - r0 - w0), 32'd0);
    chk(mem[10] == 32'h1234_5678, "R6 memory unchanged", mem[10], 32'h1234_5678);
  endtask

  task automatic t_set_clear();
    poke(11, 32'h0F0F_0000);
    issue(1'b1, alias_addr(2'b01, 11), 4'b0000, 32'h0000_00F0, 3'd0);
    chk(!sram_oe_n, "R7 bit set uses read", 32'(sram_oe_n), 32'd0);
    @(negedge clk);
    @(negedge clk);
    chk(!sram_we_n && sram_wdata == 32'h0F0F_00F0, "R8 bit set word", sram_wdata, 32'h0F0F_00F0);
    settle();
    chk(mem[11] == 32'h0F0F_00F0, "R8 bit set memory", mem[11], 32'h0F0F_00F0);
    poke(12, 32'h1234_5678);
    issue(1'b1, alias_addr(2'b10, 12), 4'b1111, 32'hFFFF_0000, 3'd0);
    settle();
    chk(mem[12] == 32'h0000_5678, "R8 bit clear memory", mem[12], 32'h0000_5678);
  endtask

  task automatic t_test_and_set();
    poke(13, 32'h0000_0001);
    issue(1'b1, alias_addr(2'b11, 13), 4'b0000, 32'h8000_0000, 3'd0);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 32'h0000_0001, "R9 old word returned", rsp_rdata, 32'h0000_0001);
    settle();
    chk(mem[13] == 32'h8000_0001, "R9 word set", mem[13], 32'h8000_0001);
    issue(1'b1, alias_addr(2'b11, 13), 4'b0000, 32'h0000_0010, 3'd0);
    @(negedge clk);
    chk(rsp_valid && rsp_rdata == 32'h8000_0001, "R9 second test-and-set", rsp_rdata, 32'h8000_0001);
    settle();
  endtask

  task automatic t_alias_plain();
    int r0;
    r0 = rd_cnt;
    issue(1'b1, alias_addr(2'b00, 14), 4'b1111, 32'h5A5A_A5A5, 3'd0);
    chk(!sram_we_n, "R7 alias plain full write direct", 32'(sram_we_n), 32'd0);
    settle();
    chk(mem[14] == 32'h5A5A_A5A5 && rd_cnt == r0, "R7 alias maps to same word", mem[14], 32'h5A5A_A5A5);
  endtask

  task automatic t_busy_ignore();
    int w0;
    poke(20, 32'hCAFE_0000);
    poke(21, 32'h0000_0000);
    w0 = wr_cnt;
    issue(1'b1, 32'd84, 4'b0011, 32'h0000_BEEF, 3'd0);
    req_valid = 1'b1; req_addr = 32'd80; req_be = 4'b1111; req_wdata = 32'hDEAD_DEAD;
    chk(req_ready == 1'b0, "R10 busy in read phase", 32'(req_ready), 32'd0);
    @(negedge clk);
    chk(req_ready == 1'b0, "R10 busy in return phase", 32'(req_ready), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready after write-back", 32'(req_ready), 32'd1);
    settle();
    chk(mem[20] == 32'hCAFE_0000, "R10 held request not taken", mem[20], 32'hCAFE_0000);
    chk(mem[21] == 32'h0000_BEEF && wr_cnt - w0 == 1, "R10 first sequence intact", mem[21], 32'h0000_BEEF);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_be = '0;
    req_wdata = '0; req_len = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_read_single();
    t_read_burst();
    t_full_write();
    t_partial_write();
    t_be_zero();
    t_set_clear();
    t_test_and_set();
    t_alias_plain();
    t_busy_ignore();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule